// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the arithmetic and logic execute stage of a small 32-bit processor core. Each cycle in which `exec_en` is high, it decodes the opcode field of `instr` and combines two operands that the register file has already read. It produces a 32-bit `result`, a write enable and the destination register index for the write-back stage. It also keeps a four-bit status register holding negative, carry, overflow and zero. That register is updated on the clock edge that ends the instruction.

The supported operations are:

- register and 12-bit-immediate add and subtract,
- compare against a register or a 16-bit immediate,
- AND, OR and XOR between two registers,
- AND, OR and XOR with a 16-bit immediate placed in one half-word or in both,
- logical and arithmetic shifts by an immediate count.

The stored carry can be used as the carry-in of an add or subtract, so wide additions chain across several words. For the half-word immediate forms the register file presents the destination register's current value on `src_a`.

The condition field, register reads, memory and control-flow instructions lie outside the block.

Top module: `int_exec_alu`

## Requirements
- R1: The opcode is `instr[27:23]` and `dest_idx` always equals `instr[22:19]`. Opcodes: add 00000, sub 00001, add-imm 00010, sub-imm 00011, and 00100, and-half 00101, or 00110, or-half 00111, shift 01000, xor 01001, xor-half 01010, compare 11000, compare-imm 11001. `wr_en` is high only when `exec_en` is high and the opcode is a known one other than the two compares.
- R2: Register add/sub return A+B+cin or A+~B+cin. Bit 1 is the carry-select bit and bit 0 the flag-hold bit. When the carry-select bit is set, cin is the stored carry flag. When it is clear, cin is 0 for add and 1 for subtract.
- R3: Immediate add/sub take B from a 12-bit immediate in `instr[14:3]`. The immediate is sign-extended when `instr[2]` is 1 and zero-extended when it is 0. Bits 1 and 0 behave as in R2.
- R4: After an add, subtract or compare, the flags become N = result bit 31, C = carry out of bit 31, V = signed overflow, Z = result equal to zero. `status` is `{N,C,V,Z}` (bit 3 to bit 0) and changes on the rising edge that ends the instruction.
- R5: When bit 0 of an instruction that has a flag-hold bit is 1, `status` does not change. That covers add, sub, their immediate forms, the logical forms and the shift.
- R6: A compare computes A minus B with cin = 1. A compare-immediate uses a sign-extended 16-bit immediate in `instr[18:3]` as B. A compare always updates all four flags and never raises `wr_en`.
- R7: Register AND/OR/XOR return the bitwise result. They update N and Z and keep C and V.
- R8: Half-word immediate logic forms take a 16-bit immediate from `instr[18:3]`.
  - When `instr[1]` (both halves) is 1, the immediate is applied to both halves of `src_a`.
  - Otherwise `instr[2]` picks the half: 1 for bits 31:16, 0 for bits 15:0. The other half of `src_a` passes through unchanged.
  - N and Z are updated; C and V are kept.
- R9: The shift has its amount in `instr[14:10]`, direction in `instr[3]` (1 = right), arithmetic fill in `instr[2]` and carry-update in `instr[1]`.
  - When carry-update is 1, C takes the last bit shifted out, or 0 for an amount of zero. Otherwise C is kept.
  - N and Z are updated and V is kept.
- R10: Multi-word addition: an add whose carry-select bit is set, following an add that carried out, adds one more.
- R11: When `exec_en` is low, or the opcode is unknown, `wr_en` is low and `status` holds its value.
- R12: Driving `rst_n` low clears `status` at once, without a clock edge. Release takes effect after two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Instruction valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Operand A (destination value for half-word logic forms) |
| src_b | input | 32 | Operand B from the register file |
| result | output | 32 | Computed value for write-back |
| wr_en | output | 1 | Destination register write enable |
| dest_idx | output | 4 | Destination register index |
| status | output | 4 | Flags {N,C,V,Z} |

## Verification
The hardest situation to reach from the ports is an operation whose result depends on the flags left behind by an earlier instruction. Examples are a carry-in taken from the status register, a carry kept through a logical operation or a non-updating shift, and flags held by the hold bit. Each such check depends on a specific history in the status register. The vector table is therefore applied in one fixed order without resets between rows, and each row's expected flags are worked out from the row before it. A row that sets carry is placed directly ahead of each row that consumes or must preserve it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int XLEN      = 32;
  localparam int OPC_W     = 5;
  localparam int RIDX_W    = 4;
  localparam int IMM_S_W   = 12;
  localparam int IMM_L_W   = 16;
  localparam int SHAMT_W   = $clog2(XLEN);

  // instruction field positions
  localparam int OPC_LSB   = 23;
  localparam int RD_LSB    = 19;
  localparam int IMMS_LSB  = 3;
  localparam int IMML_LSB  = 3;
  localparam int SHAMT_LSB = 10;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 5'b00000,
    OP_SUB   = 5'b00001,
    OP_ADDI  = 5'b00010,
    OP_SUBI  = 5'b00011,
    OP_AND   = 5'b00100,
    OP_ANDH  = 5'b00101,
    OP_OR    = 5'b00110,
    OP_ORH   = 5'b00111,
    OP_SHIFT = 5'b01000,
    OP_XOR   = 5'b01001,
    OP_XORH  = 5'b01010,
    OP_CMP   = 5'b11000,
    OP_CMPI  = 5'b11001
  } opcode_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_ARITH = 2'd1,
    K_LOGIC = 2'd2,
    K_SHIFT = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2
  } lop_e;

  typedef struct packed {
    unit_e kind;
    logic  is_sub;
    logic  use_cflag;
    logic  wr;
    logic  upd_nz;
    logic  upd_c;
    logic  upd_v;
    lop_e  lop;
    logic  sh_right;
    logic  sh_arith;
  } ctrl_t;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [27:0]  instr_lo,
  input  logic [W-1:0] src_b,
  output ctrl_t        ctrl,
  output logic [W-1:0] opb,
  output logic [W-1:0] sel_mask,
  output logic [SHAMT_W-1:0] shamt
);
  localparam int HALF = W / 2;

  logic                 c_bit, d_bit, s_bit;
  logic [IMM_S_W-1:0]   imm_s;
  logic [IMM_L_W-1:0]   imm_l;
  logic [W-1:0]         imm_s_ext, imm_l_sext, imm_l_dup;
  logic [W-1:0]         hi_mask, lo_mask;
  opcode_e              opc;

  assign opc   = opcode_e'(instr_lo[OPC_LSB +: OPC_W]);
  assign c_bit = instr_lo[1];
  assign d_bit = instr_lo[0];
  assign s_bit = instr_lo[2];
  assign imm_s = instr_lo[IMMS_LSB +: IMM_S_W];
  assign imm_l = instr_lo[IMML_LSB +: IMM_L_W];
  assign shamt = instr_lo[SHAMT_LSB +: SHAMT_W];

  assign imm_s_ext  = s_bit ? {{(W-IMM_S_W){imm_s[IMM_S_W-1]}}, imm_s}
                            : {{(W-IMM_S_W){1'b0}}, imm_s};
  assign imm_l_sext = {{(W-IMM_L_W){imm_l[IMM_L_W-1]}}, imm_l};
  assign imm_l_dup  = {(W/IMM_L_W){imm_l}};
  assign hi_mask    = {{(W-HALF){1'b1}}, {HALF{1'b0}}};
  assign lo_mask    = ~hi_mask;

  always_comb begin
    ctrl          = '0;
    ctrl.kind     = K_NONE;
    ctrl.lop      = LOP_AND;
    opb           = src_b;
    sel_mask      = '1;
    ctrl.sh_right = instr_lo[3];
    ctrl.sh_arith = instr_lo[2];
    unique case (opc)
      OP_ADD, OP_SUB, OP_ADDI, OP_SUBI: begin
        ctrl.kind      = K_ARITH;
        ctrl.is_sub    = (opc == OP_SUB) || (opc == OP_SUBI);
        ctrl.use_cflag = c_bit;
        ctrl.wr        = 1'b1;
        ctrl.upd_nz    = !d_bit;
        ctrl.upd_c     = !d_bit;
        ctrl.upd_v     = !d_bit;
        if ((opc == OP_ADDI) || (opc == OP_SUBI)) opb = imm_s_ext;
      end
      OP_CMP, OP_CMPI: begin
        ctrl.kind   = K_ARITH;
        ctrl.is_sub = 1'b1;
        ctrl.upd_nz = 1'b1;
        ctrl.upd_c  = 1'b1;
        ctrl.upd_v  = 1'b1;
        if (opc == OP_CMPI) opb = imm_l_sext;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.kind   = K_LOGIC;
        ctrl.wr     = 1'b1;
        ctrl.upd_nz = !d_bit;
        ctrl.lop    = (opc == OP_AND) ? LOP_AND :
                      (opc == OP_OR)  ? LOP_OR  : LOP_XOR;
      end
      OP_ANDH, OP_ORH, OP_XORH: begin
        ctrl.kind   = K_LOGIC;
        ctrl.wr     = 1'b1;
        ctrl.upd_nz = !d_bit;
        ctrl.lop    = (opc == OP_ANDH) ? LOP_AND :
                      (opc == OP_ORH)  ? LOP_OR  : LOP_XOR;
        opb         = imm_l_dup;
        if (c_bit)          sel_mask = '1;
        else if (s_bit)     sel_mask = hi_mask;
        else                sel_mask = lo_mask;
      end
      OP_SHIFT: begin
        ctrl.kind   = K_SHIFT;
        ctrl.wr     = 1'b1;
        ctrl.upd_nz = !d_bit;
        ctrl.upd_c  = c_bit && !d_bit;
      end
      default: ctrl.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  ctrl_t              ctrl,
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       opb,
  input  logic [W-1:0]       sel_mask,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               carry_q,
  output logic [W-1:0]       res,
  output logic               c_out,
  output logic               v_out
);
  logic [W-1:0] b_eff, logic_full, logic_res;
  logic         cin;
  logic [W:0]   sum, lext, rext;

  // adder
  assign b_eff = ctrl.is_sub ? ~opb : opb;
  assign cin   = ctrl.use_cflag ? carry_q : ctrl.is_sub;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};

  // bitwise unit with half-word merge
  always_comb begin
    unique case (ctrl.lop)
      LOP_OR:  logic_full = a | opb;
      LOP_XOR: logic_full = a ^ opb;
      default: logic_full = a & opb;
    endcase
  end
  assign logic_res = (logic_full & sel_mask) | (a & ~sel_mask);

  // shifter: one guard bit catches the last bit shifted out
  assign lext = {1'b0, a} << shamt;
  always_comb begin
    if (ctrl.sh_arith) rext = $signed({a, 1'b0}) >>> shamt;
    else               rext = {a, 1'b0} >> shamt;
  end

  always_comb begin
    res   = '0;
    c_out = 1'b0;
    v_out = 1'b0;
    unique case (ctrl.kind)
      K_ARITH: begin
        res   = sum[W-1:0];
        c_out = sum[W];
        v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
      end
      K_LOGIC: res = logic_res;
      K_SHIFT: begin
        if (ctrl.sh_right) begin
          res   = rext[W:1];
          c_out = rext[0];
        end else begin
          res   = lext[W-1:0];
          c_out = lext[W];
        end
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         exec_en,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] res,
  input  logic         c_in,
  input  logic         v_in,
  output logic [3:0]   flags_q
);
  logic [3:0] flags_d;
  logic       n_new, z_new;

  assign n_new = res[W-1];
  assign z_new = (res == '0);

  always_comb begin
    flags_d = flags_q;
    if (exec_en) begin
      if (ctrl.upd_nz) begin
        flags_d[3] = n_new;
        flags_d[0] = z_new;
      end
      if (ctrl.upd_c) flags_d[2] = c_in;
      if (ctrl.upd_v) flags_d[1] = v_in;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) flags_q <= '0;
    else          flags_q <= flags_d;
  end

  // R7
  kept_cv_logic_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && ctrl.kind == K_LOGIC) |=> (flags_q[2:1] == $past(flags_q[2:1])));
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec_en,
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic [31:0] result,
  output logic        wr_en,
  output logic [3:0]  dest_idx,
  output logic [3:0]  status
);
  localparam int W = XLEN;

  ctrl_t              ctrl;
  logic [W-1:0]       opb, sel_mask, dp_res;
  logic [SHAMT_W-1:0] shamt;
  logic               dp_c, dp_v, rst_q_n;
  logic               unused_cond;

  assign unused_cond = ^instr[31:28];

  alu_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  alu_decode #(.W(W)) u_dec (
    .instr_lo (instr[27:0]),
    .src_b    (src_b),
    .ctrl     (ctrl),
    .opb      (opb),
    .sel_mask (sel_mask),
    .shamt    (shamt)
  );

  alu_datapath #(.W(W)) u_dp (
    .ctrl     (ctrl),
    .a        (src_a),
    .opb      (opb),
    .sel_mask (sel_mask),
    .shamt    (shamt),
    .carry_q  (status[2]),
    .res      (dp_res),
    .c_out    (dp_c),
    .v_out    (dp_v)
  );

  alu_flags #(.W(W)) u_flg (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .exec_en (exec_en),
    .ctrl    (ctrl),
    .res     (dp_res),
    .c_in    (dp_c),
    .v_in    (dp_v),
    .flags_q (status)
  );

  assign result   = dp_res;
  assign wr_en    = exec_en && ctrl.wr;
  assign dest_idx = instr[RD_LSB +: RIDX_W];

  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (instr[27:23] == OP_CMP || instr[27:23] == OP_CMPI) |-> !wr_en);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !exec_en |=> $stable(status));

  // R5
  dbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && instr[0] && instr[27:23] != OP_CMP && instr[27:23] != OP_CMPI)
      |=> $stable(status));

  // R9
  shift_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && instr[27:23] == OP_SHIFT && !instr[1]) |=> $stable(status[2]));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exec_en && !instr[0] && (instr[27:23] == OP_ADD || instr[27:23] == OP_SUB))
      |=> (status[0] == ($past(result) == '0)));
endmodule

// File: tb/int_exec_alu_tb.sv
module int_exec_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  function automatic logic [31:0] mk_rr(input logic [4:0] op, input logic c, input logic d);
    return {4'h0, op, 4'd1, 4'd2, 4'd3, 9'd0, c, d};
  endfunction
  function automatic logic [31:0] mk_ri(input logic [4:0] op, input logic [11:0] imm,
                                        input logic s, input logic c, input logic d);
    return {4'h0, op, 4'd1, 4'd2, imm, s, c, d};
  endfunction
  function automatic logic [31:0] mk_lr(input logic [4:0] op);
    return {4'h0, op, 4'd1, 4'd2, 4'd3, 10'd0, 1'b0};
  endfunction
  function automatic logic [31:0] mk_lh(input logic [4:0] op, input logic [15:0] imm,
                                        input logic hl, input logic f);
    return {4'h0, op, 4'd1, imm, hl, f, 1'b0};
  endfunction
  function automatic logic [31:0] mk_sh(input logic [4:0] amt, input logic rt,
                                        input logic ar, input logic c);
    return {4'h0, 5'b01000, 4'd1, 4'd2, amt, 6'd0, rt, ar, c, 1'b0};
  endfunction
  function automatic logic [31:0] mk_cr();
    return {4'h0, 5'b11000, 4'd2, 4'd3, 15'd0};
  endfunction
  function automatic logic [31:0] mk_ci(input logic [15:0] imm);
    return {4'h0, 5'b11001, 4'd2, imm, 3'd0};
  endfunction

  localparam logic [4:0] ADD = 5'b00000, SUB = 5'b00001, ADDI = 5'b00010, SUBI = 5'b00011,
                         AND_ = 5'b00100, ANDH = 5'b00101, OR_ = 5'b00110, ORH = 5'b00111,
                         XOR_ = 5'b01001, XORH = 5'b01010;

  localparam logic [31:0] V_INSTR [NV] = '{
    mk_rr(ADD,0,0), mk_rr(ADD,0,0), mk_rr(ADD,1,0), mk_rr(SUB,0,0),
    mk_rr(SUB,0,0), mk_rr(SUB,1,0), mk_rr(ADD,0,0), mk_rr(SUB,0,0),
    mk_ri(ADDI,12'hFFF,1,0,0), mk_ri(ADDI,12'hFFF,0,0,1), mk_ri(SUBI,12'h001,0,0,0), mk_cr(),
    mk_ci(16'hFFFF), mk_rr(ADD,0,0), mk_lr(AND_), mk_lr(OR_),
    mk_lr(XOR_), mk_lh(ANDH,16'h00F0,0,0), mk_lh(ORH,16'h8000,1,0), mk_lh(XORH,16'hFFFF,0,1),
    mk_lh(XORH,16'hFFFF,0,0), mk_sh(5'd4,0,0,1), mk_sh(5'd1,1,0,0), mk_sh(5'd4,1,1,1),
    mk_sh(5'd0,0,0,1), mk_rr(ADD,0,0), {4'h0,5'b11111,23'd0}, mk_rr(ADD,1,0)};
  localparam logic [31:0] V_A [NV] = '{
    32'd5, 32'hFFFFFFFF, 32'd1, 32'd5, 32'd3, 32'd10, 32'h7FFFFFFF, 32'h80000000,
    32'd10, 32'd1, 32'd0, 32'd2, 32'd0, 32'hFFFFFFFF, 32'hF0000000, 32'h80000000,
    32'hFFFF0000, 32'h12345678, 32'h00001111, 32'h0F0F0F0F, 32'h0000FFFF, 32'hF0000001,
    32'h80000002, 32'h80000018, 32'd5, 32'hFFFFFFFF, 32'd0, 32'd0};
  localparam logic [31:0] V_B [NV] = '{
    32'd3, 32'd1, 32'd2, 32'd5, 32'd5, 32'd3, 32'd1, 32'd1,
    32'd0, 32'd0, 32'd0, 32'd2, 32'd0, 32'hFFFFFFFF, 32'h0F000000, 32'd1,
    32'hFFFFFFFF, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd1, 32'd0, 32'd0};
  localparam logic [31:0] V_RES [NV] = '{
    32'd8, 32'd0, 32'd4, 32'd0, 32'hFFFFFFFE, 32'd6, 32'h80000000, 32'h7FFFFFFF,
    32'd9, 32'h00001000, 32'hFFFFFFFF, 32'd0, 32'd0, 32'hFFFFFFFE, 32'd0, 32'h80000001,
    32'h0000FFFF, 32'h12340070, 32'h80001111, 32'hF0F0F0F0, 32'd0, 32'h00000010,
    32'h40000001, 32'hF8000001, 32'd5, 32'd0, 32'd0, 32'd1};
  localparam logic V_WE [NV] = '{
    1,1,1,1,1,1,1,1, 1,1,1,0,0,1,1,1, 1,1,1,1,1,1,1,1, 1,1,0,1};
  localparam logic [3:0] V_FLG [NV] = '{
    4'b0000, 4'b0101, 4'b0000, 4'b0101, 4'b1000, 4'b0100, 4'b1010, 4'b0110,
    4'b0100, 4'b0100, 4'b1000, 4'b0101, 4'b0000, 4'b1100, 4'b0101, 4'b1100,
    4'b0100, 4'b0100, 4'b1100, 4'b1100, 4'b0101, 4'b0100, 4'b0100, 4'b1100,
    4'b0000, 4'b0101, 4'b0101, 4'b0000};
  localparam string V_REQ [NV] = '{
    "R2", "R4", "R2", "R4", "R4", "R2", "R4", "R4",
    "R3", "R5", "R3", "R6", "R6", "R4", "R7", "R7",
    "R7", "R8", "R8", "R8", "R8", "R9", "R9", "R9",
    "R9", "R10", "R11", "R10"};

  logic        clk, rst_n, exec_en, wr_en;
  logic [31:0] instr, src_a, src_b, result;
  logic [3:0]  dest_idx, status;
  int          n_chk, n_bad;
  bit          done;

  int_exec_alu u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .src_a(src_a), .src_b(src_b), .result(result), .wr_en(wr_en),
    .dest_idx(dest_idx), .status(status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; exec_en = 1'b0; instr = '0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R12", "status at reset", {28'd0, status}, 32'd0);
    check("R11", "wr_en idle", {31'd0, wr_en}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk; flags carry from row to row
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      exec_en = 1'b1; instr = V_INSTR[i]; src_a = V_A[i]; src_b = V_B[i];
      #1;
      check("R1", "wr_en", {31'd0, wr_en}, {31'd0, V_WE[i]});
      check("R1", "dest_idx", {28'd0, dest_idx}, {28'd0, instr[22:19]});
      if (V_WE[i]) check(V_REQ[i], "result", result, V_RES[i]);
      @(posedge clk);
      #1;
      check(V_REQ[i], "status", {28'd0, status}, {28'd0, V_FLG[i]});
    end

    // R11: exec_en low, an add that would overflow must leave flags
    @(negedge clk);
    exec_en = 1'b0; instr = mk_rr(ADD,0,0); src_a = 32'h7FFFFFFF; src_b = 32'd1;
    #1;
    check("R11", "wr_en with exec_en low", {31'd0, wr_en}, 32'd0);
    @(posedge clk); #1;
    check("R11", "status with exec_en low", {28'd0, status}, 32'd0);

    // R5: hold bit on a shift that would set carry and N
    @(negedge clk);
    exec_en = 1'b1; instr = mk_sh(5'd1,0,0,1) | 32'd1; src_a = 32'hC0000000;
    @(posedge clk); #1;
    check("R5", "status with hold bit on shift", {28'd0, status}, 32'd0);

    // R12: set flags, then assert reset between edges
    @(negedge clk);
    instr = mk_rr(ADD,0,0); src_a = 32'h7FFFFFFF; src_b = 32'd1;
    @(posedge clk); #1;
    check("R4", "overflow before reset", {28'd0, status}, 32'h0000000A);
    #2 rst_n = 1'b0; exec_en = 1'b0;
    #1;
    check("R12", "status cleared asynchronously", {28'd0, status}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    exec_en = 1'b1;
    @(posedge clk); #1;
    check("R12", "flags held during release", {28'd0, status}, 32'd0);
    @(negedge clk) exec_en = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule